// File: doc/BRIEF.md
# Three-Channel Interval Timer Core

This block is a byte-wide register front end and counting core for three independent 16-bit down counters. A host writes control words and count bytes over a small parallel bus: a 2-bit address, a write strobe with write data, and a read strobe. Read data comes back combinationally in the same cycle as the read strobe. Each counter has a tick input, a gate input and an output. The tick is a single-cycle count enable sampled on the system clock.

One address holds the control register. The other three each reach one counter, for both count data and status. A host programs a counter with a control word and then loads its initial count one byte at a time. It can take a consistent snapshot of a running count with a latch command, or capture a status byte with a read-back command. Binary down-counting is built for two behaviours: a one-shot terminal-count output and a periodic rate generator. Every other mode code is stored and reported, and those modes count with one of these two behaviours.

Top module: `tri_interval_timer`

## Requirements
- R1: Address 3 is the control register and addresses 0..2 reach counters 0..2. In a control word, bits 7:6 pick the counter (3 means read-back), bits 5:4 the access kind, bits 3:1 the mode and bit 0 the decimal flag. The decimal flag is stored and reported, but counting is always binary.
- R2: With access kind 11, the count is written low byte then high byte at the counter's own address. Reads of the count alternate low byte then high byte in the same way.
- R3: A control word with access bits 00 is a latch command. It freezes the count held at that clock edge, even if a tick lands in the same cycle. The next reads return that frozen value while counting goes on. A second latch command is ignored until the frozen value has been fully read.
- R4: A read-back word (bits 7:6 = 11) acts on every counter n whose bit n+1 is set. Bit 4 = 0 captures status and bit 5 = 0 captures the count. A captured status is returned by the next read at that counter before any count byte.
- R5: The status byte carries the output level in bit 7, the null-count flag in bit 6, and the access, mode and decimal bits of the last control word in bits 5:0.
- R6: Programming a control word to a counter does the following: it stops the counter, resets both byte pointers, drops any pending latch or status, and sets null-count. It drives the output low in mode 0 and high in any other mode.
- R7: A complete count write is transferred into the counter on the next tick, and this clears null-count. A loaded count of 0 behaves as 65536, so one further tick reads back 0xFFFF.
- R8: In mode 0 (and every mode other than 2 and 3), each tick with gate high decrements the count. The output goes high when the count reaches 0 and stays high while the count keeps wrapping, until the next write.
- R9: While a counter's gate is low, its count and its output hold. The transfer of a newly written count still happens on a tick.
- R10: In modes 2 and 3, the output is high except for one tick period while the count equals 1. The next gated tick reloads the initial count, so a count of N gives a period of N ticks.
- R11: In modes 2 and 3, a written count of 1 is rejected. The counter does not start, its output stays high and null-count stays set.
- R12: Access kind 01 loads and reads only the low byte (the high byte becomes 0). Access kind 10 loads and reads only the high byte (the low byte becomes 0). Both use one bus access each.
- R13: After reset, all outputs are high and no read is pending. Each counter reports status 0xF0: output high, null-count set, access kind 11, mode 0, binary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address (3 = control) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; side effects at the clock edge |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, 0 otherwise |
| ch_tick | input | 3 | Per-counter count enable pulses |
| ch_gate | input | 3 | Per-counter gate, high enables counting |
| ch_out | output | 3 | Per-counter output |

## Verification
A latch command can reach a counter in the same cycle as one of its ticks, so the latch capture and the decrement collide in one clock edge. The bench provokes this by driving the control write and the tick pulse inside a single cycle, then letting further ticks pass. It judges the result by reading the frozen bytes, which must be the pre-tick value. It then reads the live count, which must show every tick, including the colliding one.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
   typedef struct packed {
      logic [1:0] acc;
      logic [2:0] mode;
      logic       bcd;
   } cw_t;

   localparam logic [1:0] ACC_LATCH = 2'b00;
   localparam logic [1:0] ACC_LO    = 2'b01;
   localparam logic [1:0] ACC_HI    = 2'b10;
   localparam logic [1:0] ACC_LOHI  = 2'b11;

   localparam logic [2:0] MODE_TC   = 3'd0;
   localparam logic [1:0] CTRL_ADDR = 2'd3;
endpackage

// File: rtl/tri_timer_decode.sv
module tri_timer_decode
   import tri_timer_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [BYTE_W-1:0] wdata,
   output cw_t               cw,
   output logic [NUM_CH-1:0] cw_prog,
   output logic [NUM_CH-1:0] cnt_latch,
   output logic [NUM_CH-1:0] st_latch,
   output logic [NUM_CH-1:0] data_wr
);
   logic       ctrl;
   logic       is_rb;
   logic [1:0] sel;

   assign ctrl  = wr_en && (addr == CTRL_ADDR);
   assign sel   = wdata[7:6];
   assign is_rb = (sel == 2'd3);
   assign cw    = cw_t'(wdata[5:0]);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit          = ctrl && !is_rb && (sel == 2'(i));
      assign cw_prog[i]   = hit && (wdata[5:4] != ACC_LATCH);
      assign cnt_latch[i] = (hit && (wdata[5:4] == ACC_LATCH))
                         || (ctrl && is_rb && !wdata[5] && wdata[i+1]);
      assign st_latch[i]  = ctrl && is_rb && !wdata[4] && wdata[i+1];
      assign data_wr[i]   = wr_en && (addr == 2'(i));
   end
endmodule

// File: rtl/tri_timer_rdmux.sv
module tri_timer_rdmux #(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input  logic                          rd_en,
   input  logic [1:0]                    addr,
   input  logic [NUM_CH-1:0][BYTE_W-1:0] ch_bytes,
   output logic [NUM_CH-1:0]             rd_strobe,
   output logic [BYTE_W-1:0]             rdata
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_stb
      assign rd_strobe[i] = rd_en && (addr == 2'(i));
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (rd_strobe[i]) rdata = ch_bytes[i];
   end
endmodule

// File: rtl/tri_timer_channel.sv
module tri_timer_channel
   import tri_timer_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_prog,
   input  cw_t               cw,
   input  logic              cnt_latch,
   input  logic              st_latch,
   input  logic              data_wr,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              rd_strobe,
   input  logic              tick,
   input  logic              gate,
   output logic              out,
   output logic [BYTE_W-1:0] rd_byte,
   output logic [2:0]        mode_o,
   output logic              null_o
);
   localparam int CNT_W = 2 * BYTE_W;

   cw_t               cfg_q;
   logic              out_q, null_q, wr_hi_q, rd_hi_q, lat_q, st_q, pend_q, run_q;
   logic [BYTE_W-1:0] lo_hold_q, st_byte_q;
   logic [CNT_W-1:0]  init_q, cnt_q, lat_val_q;

   logic              rate_like, wr_done, bad_cnt, hi_sel, rd_last;
   logic [CNT_W-1:0]  wr_val, src;

   assign rate_like = (cfg_q.mode == 3'd2) || (cfg_q.mode == 3'd3);

   always_comb begin
      wr_done = 1'b0;
      wr_val  = '0;
      unique case (cfg_q.acc)
         ACC_LO:   begin wr_done = data_wr; wr_val = {{BYTE_W{1'b0}}, wr_byte}; end
         ACC_HI:   begin wr_done = data_wr; wr_val = {wr_byte, {BYTE_W{1'b0}}}; end
         ACC_LOHI: begin wr_done = data_wr && wr_hi_q; wr_val = {wr_byte, lo_hold_q}; end
         default:  ;
      endcase
   end

   assign bad_cnt = rate_like && (wr_val == CNT_W'(1));
   assign src     = lat_q ? lat_val_q : cnt_q;
   assign hi_sel  = (cfg_q.acc == ACC_HI) || ((cfg_q.acc == ACC_LOHI) && rd_hi_q);
   assign rd_last = (cfg_q.acc != ACC_LOHI) || rd_hi_q;
   assign rd_byte = st_q   ? st_byte_q
                  : hi_sel ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '{acc: ACC_LOHI, mode: MODE_TC, bcd: 1'b0};
         out_q     <= 1'b1;
         null_q    <= 1'b1;
         wr_hi_q   <= 1'b0;
         rd_hi_q   <= 1'b0;
         lat_q     <= 1'b0;
         st_q      <= 1'b0;
         pend_q    <= 1'b0;
         run_q     <= 1'b0;
         lo_hold_q <= '0;
         st_byte_q <= '0;
         init_q    <= '0;
         cnt_q     <= '0;
         lat_val_q <= '0;
      end else if (cw_prog) begin
         cfg_q   <= cw;
         wr_hi_q <= 1'b0;
         rd_hi_q <= 1'b0;
         lat_q   <= 1'b0;
         st_q    <= 1'b0;
         null_q  <= 1'b1;
         pend_q  <= 1'b0;
         run_q   <= 1'b0;
         out_q   <= (cw.mode != MODE_TC);
      end else begin
         // host read side effects
         if (rd_strobe) begin
            if (st_q) st_q <= 1'b0;
            else begin
               if (cfg_q.acc == ACC_LOHI) rd_hi_q <= !rd_hi_q;
               if (lat_q && rd_last) lat_q <= 1'b0;
            end
         end
         // counting
         if (tick) begin
            if (pend_q) begin
               cnt_q  <= init_q;
               pend_q <= 1'b0;
               null_q <= 1'b0;
               run_q  <= 1'b1;
               if (rate_like) out_q <= 1'b1;
            end else if (run_q && gate) begin
               if (rate_like) begin
                  if (cnt_q == CNT_W'(1)) begin
                     cnt_q <= init_q;
                     out_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                     if (cnt_q == CNT_W'(2)) out_q <= 1'b0;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
                  if (cnt_q == CNT_W'(1)) out_q <= 1'b1;
               end
            end
         end
         // count loading
         if (data_wr) begin
            if ((cfg_q.acc == ACC_LOHI) && !wr_hi_q) begin
               lo_hold_q <= wr_byte;
               wr_hi_q   <= 1'b1;
            end
            if (wr_done) begin
               wr_hi_q <= 1'b0;
               init_q  <= wr_val;
               if (bad_cnt) begin
                  pend_q <= 1'b0;
                  run_q  <= 1'b0;
               end else begin
                  pend_q <= 1'b1;
                  if (!rate_like) out_q <= 1'b0;
               end
            end
         end
         // snapshots
         if (cnt_latch && !lat_q) begin
            lat_val_q <= cnt_q;
            lat_q     <= 1'b1;
            rd_hi_q   <= 1'b0;
         end
         if (st_latch && !st_q) begin
            st_byte_q <= {out_q, null_q, cfg_q};
            st_q      <= 1'b1;
         end
      end
   end

   assign out    = out_q;
   assign mode_o = cfg_q.mode;
   assign null_o = null_q;
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
   import tri_timer_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] ch_tick,
   input  logic [NUM_CH-1:0] ch_gate,
   output logic [NUM_CH-1:0] ch_out
);
   if (BYTE_W != 8 || NUM_CH < 1 || NUM_CH > 3) begin : g_param_err
      $error("tri_interval_timer: BYTE_W must be 8 and NUM_CH 1..3");
   end

   cw_t                          cw;
   logic [NUM_CH-1:0]            cw_prog, cnt_latch, st_latch, data_wr, rd_strobe;
   logic [NUM_CH-1:0][BYTE_W-1:0] ch_bytes;
   logic [NUM_CH-1:0][2:0]       ch_mode;
   logic [NUM_CH-1:0]            ch_null;

   tri_timer_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
      .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .cw(cw),
      .cw_prog(cw_prog), .cnt_latch(cnt_latch), .st_latch(st_latch),
      .data_wr(data_wr)
   );

   tri_timer_rdmux #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_rd (
      .rd_en(bus_rd), .addr(bus_addr), .ch_bytes(ch_bytes),
      .rd_strobe(rd_strobe), .rdata(bus_rdata)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tri_timer_channel #(.BYTE_W(BYTE_W)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .cw_prog(cw_prog[i]), .cw(cw),
         .cnt_latch(cnt_latch[i]), .st_latch(st_latch[i]),
         .data_wr(data_wr[i]), .wr_byte(bus_wdata),
         .rd_strobe(rd_strobe[i]),
         .tick(ch_tick[i]), .gate(ch_gate[i]),
         .out(ch_out[i]), .rd_byte(ch_bytes[i]),
         .mode_o(ch_mode[i]), .null_o(ch_null[i])
      );
   end
endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk #(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [1:0]             bus_addr,
   input logic                   bus_wr,
   input logic [BYTE_W-1:0]      bus_wdata,
   input logic [NUM_CH-1:0]      ch_tick,
   input logic [NUM_CH-1:0]      ch_gate,
   input logic [NUM_CH-1:0]      ch_out,
   input logic [NUM_CH-1:0][2:0] ch_mode,
   input logic [NUM_CH-1:0]      ch_null
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R9: the output moves only after a tick or a bus write
      p_out_on_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_tick[i] && !bus_wr) |=> $stable(ch_out[i]));

      // R6: programming a counter raises its null-count flag
      p_null_after_cw_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'(i) && bus_wdata[5:4] != 2'b00)
         |=> ch_null[i]);

      // R8: in mode 0 a high output stays high until the next write
      p_mode0_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_mode[i] == 3'd0 && ch_out[i] && !bus_wr) |=> ch_out[i]);

      // R10: the low phase in mode 2 ends on the next gated tick
      p_rate_low_one_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_mode[i] == 3'd2 && !ch_out[i] && ch_tick[i] && ch_gate[i] && !bus_wr)
         |=> ch_out[i]);
   end
endmodule

bind tri_interval_timer tri_interval_timer_chk #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .ch_tick(ch_tick), .ch_gate(ch_gate),
   .ch_out(ch_out), .ch_mode(ch_mode), .ch_null(ch_null)
);

// File: tb/tri_interval_timer_tb.sv
module tri_interval_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic [2:0] ch_tick = '0;
   logic [2:0] ch_gate = 3'b111;
   logic [2:0] ch_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   tri_interval_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ch_tick(ch_tick), .ch_gate(ch_gate), .ch_out(ch_out)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_tick(input logic [1:0] a, input logic [7:0] d, input logic [2:0] m);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; ch_tick = m;
      @(negedge clk);
      bus_wr = 1'b0; ch_tick = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic tick(input logic [2:0] m, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ch_tick = m;
         @(negedge clk);
         ch_tick = '0;
      end
   endtask

   task automatic rd16(input logic [1:0] a, output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(a, lo);
      rd(a, hi);
      v = {hi, lo};
   endtask

   task automatic t_reset();
      logic [7:0] s;
      chk("R13 outputs after reset", 16'(ch_out), 16'h7);
      chk("R13 idle read data", 16'(bus_rdata), 16'h0);
      wr(2'd3, 8'hE2);
      rd(2'd0, s);
      chk("R13/R4 reset status ch0", 16'(s), 16'hF0);
   endtask

   task automatic t_mode0();
      logic [15:0] v;
      wr(2'd3, 8'h30);
      chk("R6 mode0 out low after control word", 16'(ch_out[0]), 16'h0);
      wr(2'd0, 8'h05);
      wr(2'd0, 8'h00);
      tick(3'b001, 1);
      tick(3'b001, 4);
      chk("R8 out still low at count 1", 16'(ch_out[0]), 16'h0);
      tick(3'b001, 1);
      chk("R8 out high at terminal count", 16'(ch_out[0]), 16'h1);
      tick(3'b001, 2);
      chk("R8 out stays high after wrap", 16'(ch_out[0]), 16'h1);
      rd16(2'd0, v);
      chk("R2/R8 wrapped count low-then-high read", v, 16'hFFFE);
   endtask

   task automatic t_gate();
      logic [15:0] v;
      wr(2'd3, 8'h70);
      wr(2'd1, 8'h03);
      wr(2'd1, 8'h00);
      ch_gate[1] = 1'b0;
      tick(3'b010, 1);
      tick(3'b010, 5);
      chk("R9 out held while gate low", 16'(ch_out[1]), 16'h0);
      rd16(2'd1, v);
      chk("R9 count held while gate low", v, 16'h0003);
      ch_gate[1] = 1'b1;
      tick(3'b010, 3);
      chk("R9 count resumes with gate high", 16'(ch_out[1]), 16'h1);
   endtask

   task automatic t_mode2();
      logic [5:0] seen;
      wr(2'd3, 8'hB4);
      chk("R6 rate mode out high after control word", 16'(ch_out[2]), 16'h1);
      wr(2'd2, 8'h03);
      wr(2'd2, 8'h00);
      for (int k = 0; k < 6; k++) begin
         tick(3'b100, 1);
         seen[k] = ch_out[2];
      end
      chk("R10 rate output over six ticks", 16'(seen), 16'b011011);
   endtask

   task automatic t_latch();
      logic [15:0] v;
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h34);
      wr(2'd0, 8'h12);
      tick(3'b001, 1);
      wr_tick(2'd3, 8'h00, 3'b001);
      tick(3'b001, 2);
      rd16(2'd0, v);
      chk("R3 latch with same-cycle tick holds pre-tick value", v, 16'h1234);
      rd16(2'd0, v);
      chk("R3 live count after latch read", v, 16'h1231);
      wr(2'd3, 8'h00);
      tick(3'b001, 1);
      wr(2'd3, 8'h00);
      rd16(2'd0, v);
      chk("R3 second latch ignored while pending", v, 16'h1231);
   endtask

   task automatic t_readback();
      logic [7:0] s;
      logic [15:0] v;
      wr(2'd3, 8'h70);
      wr(2'd1, 8'h03);
      wr(2'd1, 8'h00);
      wr(2'd3, 8'hE4);
      rd(2'd1, s);
      chk("R5 status before transfer", 16'(s), 16'h70);
      tick(3'b010, 1);
      wr(2'd3, 8'hC4);
      rd(2'd1, s);
      chk("R4/R7 status first, null cleared", 16'(s), 16'h30);
      rd16(2'd1, v);
      chk("R4 count follows status", v, 16'h0003);
   endtask

   task automatic t_bad();
      logic [7:0] s;
      wr(2'd3, 8'hB4);
      wr(2'd2, 8'h01);
      wr(2'd2, 8'h00);
      tick(3'b100, 4);
      chk("R11 out stays high on rejected count", 16'(ch_out[2]), 16'h1);
      wr(2'd3, 8'hE8);
      rd(2'd2, s);
      chk("R11/R1 status keeps null set", 16'(s), 16'hF4);
   endtask

   task automatic t_single();
      logic [7:0] b;
      wr(2'd3, 8'h10);
      wr(2'd0, 8'h07);
      tick(3'b001, 1);
      rd(2'd0, b);
      chk("R12 low-only read", 16'(b), 16'h07);
      rd(2'd0, b);
      chk("R12 low-only read has no pointer", 16'(b), 16'h07);
      wr(2'd3, 8'h20);
      wr(2'd0, 8'h02);
      tick(3'b001, 1);
      rd(2'd0, b);
      chk("R12 high-only load and read", 16'(b), 16'h02);
   endtask

   task automatic t_zero();
      logic [15:0] v;
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h00);
      tick(3'b001, 2);
      rd16(2'd0, v);
      chk("R7 zero count behaves as 65536", v, 16'hFFFF);
   endtask

   task automatic t_reprogram();
      logic [15:0] v;
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h55);
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h09);
      wr(2'd0, 8'h00);
      tick(3'b001, 1);
      rd16(2'd0, v);
      chk("R6 control word resets pointer and drops latch", v, 16'h0009);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode0();
      t_gate();
      t_mode2();
      t_latch();
      t_readback();
      t_bad();
      t_single();
      t_zero();
      t_reprogram();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule